// File: doc/BRIEF.md
# Staged Panel Power Sequencer

This block brings a flat-panel display out of power-off through six fixed steps: it strobes the display-function select, enables the panel supply, releases the LVDS serializer from shutdown, enables the backlight supply, starts the backlight PWM, and finally raises the backlight enable. A configurable wait in milliseconds follows each of the first four steps. The wait is timed against a free-running microsecond timestamp supplied from outside the block. The last two steps follow each other with no wait.

Software or a boot controller pulses `start` to begin. With `run_all` high the block walks through every remaining step on its own. With `run_all` low the block behaves as a polled engine: each `poll` pulse advances at most one step, and only once the current deadline has passed. Every enable is active high and stays on until reset. A panel can lack any of the four supply/enable outputs. When the fitted flag of an output is clear, that output stays low, but its step and the wait that follows it still take their place in the sequence. All control pins are plain levels or single-cycle pulses. The block has no data stream, so no valid/ready handshake is involved.

Top module: `panel_pwr_seq`

## Requirements
- R1: A `start` pulse seen while idle and not done executes the select step on that clock edge: `mux_sel_strobe` is high for exactly one cycle following that edge. The steps then occur strictly in the order select, panel supply, LVDS release, backlight supply, PWM, backlight enable.
- R2: After step k (k = 0 for select, 1 panel, 2 LVDS, 3 backlight supply), step k+1 fires on the first edge at which `us_now` has reached the step-k timestamp plus 1000 times delay k. Delay k sits in `delay_ms[8k+7:8k]`. A zero delay lets the next step fire on the following edge.
- R3: The PWM and backlight-enable steps add no wait. Backlight enable rises one cycle after the PWM enable, and `done` rises in the same cycle as backlight enable.
- R4: `fit` bit 0 gates the panel supply, bit 1 the LVDS release, bit 2 the backlight supply and bit 3 the backlight enable. An output whose bit is clear never rises, and the timing of the later steps is unchanged.
- R5: With `run_all` high the sequence runs to `done` without any `poll`.
- R6: With `run_all` low a step fires only on an edge where `poll` is high and the deadline has passed. A poll before the deadline, or a deadline passing with no poll, makes no progress. A single-cycle poll advances exactly one step.
- R7: Once `done` is set it stays set with `busy` low, and later `start` or `poll` pulses change no output.
- R8: Reset clears every output. An enable that has risen stays high until the next reset.
- R9: From the PWM step onward the PWM settings read duty 0xDF, frequency 32768 Hz and divider 1. Before that step all three read zero.
- R10: Deadline comparison is wrap-safe: a deadline that crosses the 32-bit rollover of `us_now` still expires after the programmed wait.
- R11: A `start` pulse during a running sequence is ignored: there is no second strobe and no restart of timing.
- R12: The delays and `fit` flags are captured when the sequence starts. Changing the inputs later has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence (pulse) |
| run_all | input | 1 | 1: run every step automatically; 0: advance on poll |
| poll | input | 1 | Request one step in polled mode |
| us_now | input | 32 | Free-running microsecond timestamp |
| delay_ms | input | 32 | Four 8-bit post-step delays in ms, step k in bits 8k+7:8k |
| fit | input | 4 | Fitted flags: panel, LVDS, backlight supply, backlight enable |
| mux_sel_strobe | output | 1 | One-cycle display-function select strobe |
| panel_pwr_en | output | 1 | Panel supply enable |
| lvds_run | output | 1 | LVDS shutdown released |
| bl_pwr_en | output | 1 | Backlight supply enable |
| bl_pwm_en | output | 1 | Backlight PWM running |
| bl_pwm_duty | output | 8 | PWM compare value |
| bl_pwm_freq | output | 16 | PWM frequency in Hz |
| bl_pwm_div | output | 4 | PWM divider |
| bl_en | output | 1 | Backlight enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |

## Verification
The bench runs the sequence in automatic mode over all sixteen fitted-flag patterns, with delay patterns derived from the same index. This separates a missing output from a slipped slot, and a zero delay from a one-millisecond delay. Further runs use unequal multi-millisecond delays, a timestamp that rolls over inside the first wait, and polled mode with polls placed before, at and after a deadline. These runs tell apart early firing, firing without a request, and firing more than one step per poll. A restart attempt with changed configuration while busy, and start or poll pulses after completion, show that the latched state and the sticky outputs are untouched.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_SELECT = 3'd0,
    ST_PANEL  = 3'd1,
    ST_LVDS   = 3'd2,
    ST_BLVDD  = 3'd3,
    ST_PWM    = 3'd4,
    ST_BLEN   = 3'd5,
    ST_DONE   = 3'd6
  } step_e;

  localparam int N_TIMED   = 4;
  localparam int N_OPT     = 4;
  localparam int US_PER_MS = 1000;
endpackage

// File: rtl/pps_deadline.sv
module pps_deadline #(
  parameter int TW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          no_wait,
  input  logic [DW-1:0] wait_ms,
  input  logic [TW-1:0] now,
  output logic          reached
);
  import pps_pkg::*;

  logic [TW-1:0] deadline_q;
  logic [TW-1:0] wait_us;
  logic [TW-1:0] diff;

  assign wait_us = no_wait ? '0 : TW'(wait_ms) * TW'(US_PER_MS);
  assign diff    = now - deadline_q;
  assign reached = ~diff[TW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    deadline_q <= '0;
    else if (load) deadline_q <= now + wait_us;
  end

  // a freshly loaded non-zero wait must not be expired one cycle later
  assert_wait_not_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !no_wait && wait_ms != '0) |=> !reached);
endmodule

// File: rtl/pps_outputs.sv
module pps_outputs
  import pps_pkg::*;
#(
  parameter logic [7:0]  PWM_DUTY = 8'hDF,
  parameter logic [15:0] PWM_FREQ = 16'd32768,
  parameter logic [3:0]  PWM_DIV  = 4'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  step_e            step,
  input  logic [N_OPT-1:0] fit,
  output logic             mux_strobe,
  output logic [N_OPT-1:0] opt_en,
  output logic             pwm_en,
  output logic [7:0]       pwm_duty,
  output logic [15:0]      pwm_freq,
  output logic [3:0]       pwm_div
);
  function automatic step_e opt_step(input int idx);
    case (idx)
      0:       return ST_PANEL;
      1:       return ST_LVDS;
      2:       return ST_BLVDD;
      default: return ST_BLEN;
    endcase
  endfunction

  logic [N_OPT-1:0] en_q;

  for (genvar i = 0; i < N_OPT; i++) begin : g_opt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        en_q[i] <= 1'b0;
      else if (fire && step == opt_step(i) && fit[i])    en_q[i] <= 1'b1;
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[i] |=> en_q[i]);
    assert_unfit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !fit[i]) |=> (en_q[i] == $past(en_q[i])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_strobe <= 1'b0;
      pwm_en     <= 1'b0;
    end else begin
      mux_strobe <= fire && step == ST_SELECT;
      if (fire && step == ST_PWM) pwm_en <= 1'b1;
    end
  end

  assign opt_en   = en_q;
  assign pwm_duty = pwm_en ? PWM_DUTY : 8'd0;
  assign pwm_freq = pwm_en ? PWM_FREQ : 16'd0;
  assign pwm_div  = pwm_en ? PWM_DIV  : 4'd0;

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mux_strobe |=> !mux_strobe);
  assert_pwm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |=> pwm_en);
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int TW = 32,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  run_all,
  input  logic                  poll,
  input  logic [TW-1:0]         us_now,
  input  logic [N_TIMED*DW-1:0] delay_ms,
  input  logic [N_OPT-1:0]      fit,
  output logic                  mux_sel_strobe,
  output logic                  panel_pwr_en,
  output logic                  lvds_run,
  output logic                  bl_pwr_en,
  output logic                  bl_pwm_en,
  output logic [7:0]            bl_pwm_duty,
  output logic [15:0]           bl_pwm_freq,
  output logic [3:0]            bl_pwm_div,
  output logic                  bl_en,
  output logic                  busy,
  output logic                  done
);
  localparam int IW = $clog2(N_TIMED);

  step_e                  step_q;
  step_e                  cur_step;
  logic                   busy_q, done_q;
  logic [N_TIMED*DW-1:0]  dly_q;
  logic [N_OPT-1:0]       fit_q;
  logic                   accept, advance, fire, reached, no_wait;
  logic [DW-1:0]          sel_wait;
  logic [IW-1:0]          dly_idx;
  logic [N_OPT-1:0]       opt_en;

  assign accept   = start && !busy_q && !done_q;
  assign advance  = busy_q && reached && (run_all || poll);
  assign fire     = accept || advance;
  assign cur_step = accept ? ST_SELECT : step_q;
  assign no_wait  = int'(cur_step) >= N_TIMED;
  assign dly_idx  = step_q[IW-1:0];
  assign sel_wait = accept ? delay_ms[DW-1:0] : dly_q[dly_idx*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_SELECT;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dly_q  <= '0;
      fit_q  <= '0;
    end else if (accept) begin
      step_q <= ST_PANEL;
      busy_q <= 1'b1;
      dly_q  <= delay_ms;
      fit_q  <= fit;
    end else if (advance) begin
      if (step_q == ST_BLEN) begin
        step_q <= ST_DONE;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_e'(step_q + 3'd1);
      end
    end
  end

  pps_deadline #(.TW(TW), .DW(DW)) u_deadline (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fire),
    .no_wait (no_wait),
    .wait_ms (sel_wait),
    .now     (us_now),
    .reached (reached)
  );

  pps_outputs u_outputs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .step       (cur_step),
    .fit        (fit_q),
    .mux_strobe (mux_sel_strobe),
    .opt_en     (opt_en),
    .pwm_en     (bl_pwm_en),
    .pwm_duty   (bl_pwm_duty),
    .pwm_freq   (bl_pwm_freq),
    .pwm_div    (bl_pwm_div)
  );

  assign panel_pwr_en = opt_en[0];
  assign lvds_run     = opt_en[1];
  assign bl_pwr_en    = opt_en[2];
  assign bl_en        = opt_en[3];
  assign busy         = busy_q;
  assign done         = done_q;

  assert_step_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != $past(step_q)) |-> (step_q == step_e'($past(step_q) + 3'd1)));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (done_q && $stable(opt_en)));
  assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));
  assert_blen_after_pwm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> $past(bl_pwm_en));
endmodule

// File: tb/test_panel_pwr_seq.sv
module test_panel_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, run_all = 1'b1, poll = 1'b0;
  logic [31:0] us_now = 32'd0;
  logic [31:0] delay_ms = '0;
  logic [3:0]  fit = '0;
  logic        mux_sel_strobe, panel_pwr_en, lvds_run, bl_pwr_en, bl_pwm_en, bl_en, busy, done;
  logic [7:0]  bl_pwm_duty;
  logic [15:0] bl_pwm_freq;
  logic [3:0]  bl_pwm_div;

  int          checks = 0, errors = 0;
  bit          finished = 0;
  bit   [6:0]  seen;
  logic [31:0] rise_t [7];
  int          strobe_cnt;
  bit          jump_req = 0;
  logic [31:0] jump_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_pwr_seq i_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .run_all(run_all), .poll(poll),
    .us_now(us_now), .delay_ms(delay_ms), .fit(fit),
    .mux_sel_strobe(mux_sel_strobe), .panel_pwr_en(panel_pwr_en), .lvds_run(lvds_run),
    .bl_pwr_en(bl_pwr_en), .bl_pwm_en(bl_pwm_en), .bl_pwm_duty(bl_pwm_duty),
    .bl_pwm_freq(bl_pwm_freq), .bl_pwm_div(bl_pwm_div), .bl_en(bl_en),
    .busy(busy), .done(done)
  );

  // monitor: outputs changed at the last posedge, where us_now held its current value
  always @(negedge clk) begin
    logic [6:0] sig;
    sig = {done, bl_en, bl_pwm_en, bl_pwr_en, lvds_run, panel_pwr_en, mux_sel_strobe};
    for (int k = 0; k < 7; k++)
      if (sig[k] && !seen[k]) begin seen[k] = 1'b1; rise_t[k] = us_now; end
    if (mux_sel_strobe) strobe_cnt++;
    if (jump_req) begin us_now = jump_val; jump_req = 0; end
    else us_now = us_now + 32'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 0; start = 0; poll = 0;
    tick(3);
    seen = '0; strobe_cnt = 0;
    rst_n = 1;
    tick(1);
  endtask

  task automatic pulse_start(output logic [31:0] t0);
    start = 1; t0 = us_now;
    tick(1);
    start = 0;
  endtask

  task automatic wait_done(input int limit);
    int n = 0;
    while (!seen[6] && n < limit) begin tick(1); n++; end
  endtask

  function automatic logic [31:0] gap(input logic [7:0] d);
    return (d == 0) ? 32'd1 : 32'(d) * 32'd1000;
  endfunction

  // expected step times from start time and delays
  task automatic check_run(input logic [31:0] t0, input logic [31:0] dl, input logic [3:0] ft,
                           input string tag);
    logic [31:0] e [6];
    e[0] = t0;
    for (int k = 1; k <= 4; k++) e[k] = e[k-1] + gap(dl[(k-1)*8 +: 8]);
    e[5] = e[4] + 32'd1;
    chk({tag, " R1 strobe time"}, rise_t[0], e[0]);
    chk({tag, " R1 single strobe"}, strobe_cnt, 1);
    for (int k = 0; k < 4; k++) begin
      int s = (k == 3) ? 5 : k + 1;
      if (ft[k]) chk({tag, " R2 step time"}, seen[s] ? rise_t[s] : 32'hDEAD, e[s]);
      else       chk({tag, " R4 unfit output stays low"}, 32'(seen[s]), 0);
    end
    chk({tag, " R2 pwm time"}, rise_t[4], e[4]);
    chk({tag, " R3 done time"}, seen[6] ? rise_t[6] : 32'hDEAD, e[5]);
    chk({tag, " R9 pwm duty"}, bl_pwm_duty, 8'hDF);
    chk({tag, " R9 pwm freq"}, bl_pwm_freq, 16'd32768);
    chk({tag, " R9 pwm div"}, bl_pwm_div, 4'd1);
    tick(20);
    chk({tag, " R8 sticky"}, {panel_pwr_en, lvds_run, bl_pwr_en, bl_en}, {ft[0], ft[1], ft[2], ft[3]});
    chk({tag, " R7 idle"}, {busy, done}, 2'b01);
  endtask

  task automatic run_auto(input logic [31:0] dl, input logic [3:0] ft, input string tag);
    logic [31:0] t0;
    do_reset();
    run_all = 1; delay_ms = dl; fit = ft;
    pulse_start(t0);
    wait_done(5000 * 4 + 50);
    check_run(t0, dl, ft, tag);
  endtask

  initial begin
    logic [31:0] t0, p1, dl;
    do_reset();
    // R8: reset state
    chk("R8 reset outputs", {mux_sel_strobe, panel_pwr_en, lvds_run, bl_pwr_en, bl_pwm_en, bl_en, busy, done}, 0);
    chk("R9 pwm idle", {bl_pwm_duty, bl_pwm_freq, bl_pwm_div}, 0);

    // R5/R2/R4 sweep over fitted patterns and 0/1 ms delays
    for (int i = 0; i < 16; i++) begin
      dl = '0;
      for (int k = 0; k < 4; k++) dl[k*8 +: 8] = 8'((i >> k) & 1);
      run_auto(dl, 4'(i) ^ 4'b0110, "R5 sweep");
    end
    run_auto({8'd1, 8'd3, 8'd0, 8'd2}, 4'hF, "R2 mixed");

    // R10: deadline across the timestamp rollover
    do_reset();
    jump_req = 1; jump_val = 32'hFFFF_FE00;
    tick(2);
    run_all = 1; delay_ms = {8'd1, 8'd1, 8'd1, 8'd1}; fit = 4'hF;
    pulse_start(t0);
    wait_done(5000);
    check_run(t0, delay_ms, 4'hF, "R10 wrap");

    // R6: polled mode
    do_reset();
    run_all = 0; delay_ms = {8'd0, 8'd0, 8'd1, 8'd1}; fit = 4'hF;
    pulse_start(t0);
    while (us_now != t0 + 32'd990) tick(1);
    poll = 1; tick(1); poll = 0; tick(2);
    chk("R6 poll before deadline", panel_pwr_en, 0);
    while (us_now != t0 + 32'd1010) tick(1);
    chk("R6 no poll no progress", panel_pwr_en, 0);
    poll = 1; p1 = us_now; tick(1); poll = 0; tick(3);
    chk("R6 poll advances", panel_pwr_en, 1);
    chk("R6 poll step time", rise_t[1], p1);
    chk("R6 one step per poll", lvds_run, 0);
    poll = 1;
    wait_done(3000);
    poll = 0;
    chk("R6 lvds time", rise_t[2], p1 + 32'd1000);
    chk("R6 blvdd time", rise_t[3], p1 + 32'd1001);
    chk("R3 blen after pwm", rise_t[5], rise_t[4] + 32'd1);
    // R7: requests after done
    start = 1; poll = 1; tick(1); start = 0; poll = 0; tick(1);
    run_all = 1; poll = 1; tick(5); poll = 0;
    chk("R7 no strobe after done", strobe_cnt, 1);
    chk("R7 outputs kept", {panel_pwr_en, lvds_run, bl_pwr_en, bl_pwm_en, bl_en, busy, done}, 7'b1111101);

    // R11/R12: restart attempt with changed config while busy
    do_reset();
    run_all = 1; delay_ms = {8'd1, 8'd1, 8'd1, 8'd2}; fit = 4'hF;
    pulse_start(t0);
    tick(100);
    delay_ms = '0; fit = 4'h0;
    start = 1; tick(1); start = 0;
    wait_done(6000);
    chk("R11 ignored start", strobe_cnt, 1);
    chk("R12 latched delay", rise_t[1], t0 + 32'd2000);
    chk("R12 latched later delay", rise_t[2], t0 + 32'd3000);
    chk("R12 latched fit", bl_en, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule